// File: doc/BRIEF.md
# Reset Cause Capture Unit

This block records which reset source brought the system down most recently. Four sources feed it: a power-on request, an external reset request, a brown-out request and a watchdog bite. The power-on request acts asynchronously on the whole unit. The external and brown-out requests come from outside the clock domain and are synchronised first. The watchdog arrives as a pulse that is already synchronous to the clock. The unit merges every source into one system reset output. That output is held for a parameterised number of clocks after the last active source goes away.

Each source owns one sticky flag in a small status register. Software reads the register to learn why the system restarted, and clears flags by writing zeros to them. Writing ones leaves the register unchanged. A flag that software leaves set survives later non-power-on resets. So once software has cleared the register, the flags it finds after the next reset name that reset's cause. A power-on reset is the only event that wipes the other flags, and its own flag is cleared only by software.

Top module: `rst_cause_unit`

## Requirements
- R1: The register reads back the watchdog flag on bit 3, the brown-out flag on bit 2, the external flag on bit 1 and the power-on flag on bit 0. Bits 7 to 4 always read 0.
- R2: While the power-on request is high, and after it is released, the register reads 0x01 until another event or a write changes it.
- R3: The external and brown-out requests each pass through two flip-flops before they act. A request that is high before clock edge 1 is not yet visible in the flags after edge 2 and is visible after edge 3.
- R4: A one-cycle watchdog pulse sampled at a clock edge sets bit 3, and the flag is readable right after that edge.
- R5: A write with bit k equal to 0 clears flag k on the write edge. Flags whose bits are written as 1 keep their value.
- R6: Writing 1 to a cleared flag bit leaves it cleared. Software cannot set a flag.
- R7: External, brown-out and watchdog resets leave every flag that is already set unchanged. The flag register is not cleared by the system reset output.
- R8: A power-on reset clears the watchdog, brown-out and external flags and sets the power-on flag.
- R9: The power-on flag is cleared only by a software write of 0 to bit 0. No other reset event clears it.
- R10: When a clearing write and a reset event hit the same flag in the same cycle, the flag ends set.
- R11: The system reset output is high while the power-on request is high. It is also high in the cycle after any clock edge that samples an active synchronised source. It stays high for exactly STRETCH clock edges after the last such edge; after a power-on release it stays high for STRETCH sampled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, asynchronous, active high |
| ext_req_a | input | 1 | External reset request, asynchronous level, active high |
| bod_req_a | input | 1 | Brown-out reset request, asynchronous level, active high |
| wdt_evt | input | 1 | Watchdog bite, one-cycle synchronous pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data; a 0 on a flag bit clears that flag |
| rd_data | output | REG_W | Register read value |
| sys_rst | output | 1 | Stretched combined system reset, active high |

## Verification
A software clear and a reset event can land on the same flag in the same clock cycle. The bench provokes this by raising the watchdog pulse in the very cycle it writes all zeros to the register. It then judges the register right after that edge: bit 3 must read set while the untouched bits read clear. A second overlap is the write traffic that continues while the stretched reset output is still high. The bench clears and probes flags during that window and expects the flags to follow the write rules regardless of the reset output.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
    localparam int FLAG_W  = 4;
    localparam int BIT_POR = 0;
    localparam int BIT_EXT = 1;
    localparam int BIT_BOD = 2;
    localparam int BIT_WDT = 3;
    localparam logic [FLAG_W-1:0] FLAGS_AT_POR = FLAG_W'(1) << BIT_POR;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } flag_state_t;
endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_a;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) st_q <= '0;
        else      st_q <= st_d;
    end

    assign q = st_q.s2;

    // R3: the second stage only repeats what the first stage held one edge earlier
    a_r3_two_stage: assert property (@(posedge clk) disable iff (arst)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/rcu_flags.sv
module rcu_flags
    import rcu_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic [FLAG_W-1:0] set_vec,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_val,
    output logic [FLAG_W-1:0] flags
);
    flag_state_t st_d, st_q;
    logic [FLAG_W-1:0] clr_vec;

    always_comb begin
        clr_vec     = wr_en ? ~wr_val : '0;
        st_d        = st_q;
        st_d.flags  = (st_q.flags & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) st_q.flags <= FLAGS_AT_POR;
        else     st_q       <= st_d;
    end

    assign flags = st_q.flags;

    for (genvar k = 0; k < FLAG_W; k++) begin : g_chk
        // R10 / R4: an event always leaves its flag set
        a_r10_event_wins: assert property (@(posedge clk) disable iff (por)
            set_vec[k] |=> flags[k]);
        // R6: a clear flag cannot be set by software
        a_r6_no_sw_set: assert property (@(posedge clk) disable iff (por)
            (!flags[k] && !set_vec[k]) |=> !flags[k]);
        // R7 / R9: a set flag stays set unless software writes 0 to it
        a_r7_sticky: assert property (@(posedge clk) disable iff (por)
            (flags[k] && !(wr_en && !wr_val[k])) |=> flags[k]);
        // R5: a 0 written with no event clears the flag
        a_r5_clear: assert property (@(posedge clk) disable iff (por)
            (wr_en && !wr_val[k] && !set_vec[k]) |=> !flags[k]);
    end
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
    parameter int STRETCH = 8
) (
    input  logic clk,
    input  logic por,
    input  logic src_any,
    output logic sys_rst
);
    localparam int CW = $clog2(STRETCH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(STRETCH);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } str_t;

    str_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_any)              st_d.cnt = CNT_MAX;
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) st_q.cnt <= CNT_MAX;
        else     st_q     <= st_d;
    end

    assign sys_rst = (st_q.cnt != '0);

    // R11: an active source yields reset on the following cycle
    a_r11_src_asserts: assert property (@(posedge clk) disable iff (por)
        src_any |=> sys_rst);
    // R11: reset only drops when no source was present at the previous edge
    a_r11_fall_quiet: assert property (@(posedge clk) disable iff (por)
        (sys_rst && src_any) |=> sys_rst);
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rcu_pkg::*;
#(
    parameter int STRETCH = 8,
    parameter int REG_W   = 8
) (
    input  logic             clk,
    input  logic             por_req,
    input  logic             ext_req_a,
    input  logic             bod_req_a,
    input  logic             wdt_evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             sys_rst
);
    localparam int HI_W = REG_W - FLAG_W;

    logic [1:0]        req_s;
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] flags;
    logic              src_any;
    logic              unused_hi;

    rcu_sync #(.W(2)) u_sync (
        .clk  (clk),
        .arst (por_req),
        .d_a  ({bod_req_a, ext_req_a}),
        .q    (req_s)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_EXT] = req_s[0];
        set_vec[BIT_BOD] = req_s[1];
        set_vec[BIT_WDT] = wdt_evt;
        src_any          = |set_vec;
    end

    rcu_flags u_flags (
        .clk     (clk),
        .por     (por_req),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_val  (wr_data[FLAG_W-1:0]),
        .flags   (flags)
    );

    rcu_stretch #(.STRETCH(STRETCH)) u_stretch (
        .clk     (clk),
        .por     (por_req),
        .src_any (src_any),
        .sys_rst (sys_rst)
    );

    assign unused_hi = ^wr_data[REG_W-1:FLAG_W];
    assign rd_data   = {{HI_W{1'b0}}, flags};

    // R9: the power-on flag falls only on a software write of 0 to bit 0
    a_r9_por_flag_sw_only: assert property (@(posedge clk) disable iff (por_req)
        $fell(rd_data[BIT_POR]) |-> $past(wr_en && !wr_data[BIT_POR]));
endmodule

// File: tb/rst_cause_unit_bench.sv
module rst_cause_unit_bench;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       por_req = 1'b1;
    logic       ext_req_a = 1'b0;
    logic       bod_req_a = 1'b0;
    logic       wdt_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sys_rst;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rst_cause_unit #(.STRETCH(S), .REG_W(8)) u_rst_cause_unit (
        .clk(clk), .por_req(por_req), .ext_req_a(ext_req_a), .bod_req_a(bod_req_a),
        .wdt_evt(wdt_evt), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (sys_rst && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < S + 6; i++) @(negedge clk);
    endtask

    task automatic sw_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_por_start();
        int n;
        repeat (3) @(negedge clk);
        chk("R2 flags during power-on", int'(rd_data), 8'h01);
        chk("R11 reset during power-on", int'(sys_rst), 1);
        por_req = 1'b0;
        #1;
        count_high(n);
        chk("R11 stretch after power-on", n, S);
        chk("R1 R2 flags after power-on", int'(rd_data), 8'h01);
    endtask

    task automatic t_ext();
        ext_req_a = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 ext not visible after 2 edges", int'(rd_data), 8'h01);
        @(negedge clk);
        chk("R3 R1 ext flag on bit 1", int'(rd_data), 8'h03);
        chk("R11 reset with ext", int'(sys_rst), 1);
        ext_req_a = 1'b0;
        wait_idle();
        chk("R11 reset released after ext", int'(sys_rst), 0);
        chk("R7 flags kept after ext reset", int'(rd_data), 8'h03);
    endtask

    task automatic t_bod();
        bod_req_a = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 bod not visible after 2 edges", int'(rd_data), 8'h03);
        @(negedge clk);
        chk("R3 R1 bod flag on bit 2", int'(rd_data), 8'h07);
        bod_req_a = 1'b0;
        wait_idle();
        chk("R7 flags kept after bod reset", int'(rd_data), 8'h07);
    endtask

    task automatic t_wdt();
        int n;
        wdt_evt = 1'b1;
        @(negedge clk);
        wdt_evt = 1'b0;
        chk("R4 R1 wdt flag on bit 3", int'(rd_data), 8'h0F);
        count_high(n);
        chk("R11 stretch after wdt pulse", n, S);
        chk("R9 por flag survives other resets", int'(rd_data[0]), 1);
    endtask

    task automatic t_clear();
        sw_write(8'hFD);
        chk("R5 write 0 clears ext only", int'(rd_data), 8'h0D);
        sw_write(8'hFF);
        chk("R6 write 1 does not set", int'(rd_data), 8'h0D);
        sw_write(8'hFE);
        chk("R9 sw clears por flag", int'(rd_data), 8'h0C);
        sw_write(8'h00);
        chk("R5 clear all", int'(rd_data), 8'h00);
    endtask

    task automatic t_same_cycle();
        wdt_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk);
        wdt_evt = 1'b0; wr_en = 1'b0;
        chk("R10 event wins over clear", int'(rd_data), 8'h08);
        sw_write(8'hF7);
        chk("R5 clear during stretched reset", int'(rd_data), 8'h00);
        chk("R7 reset output independent of flags", int'(sys_rst), 1);
        wdt_evt = 1'b1;
        @(negedge clk);
        wdt_evt = 1'b0;
        wait_idle();
    endtask

    task automatic t_por_again();
        int n;
        ext_req_a = 1'b1;
        repeat (4) @(negedge clk);
        ext_req_a = 1'b0;
        wait_idle();
        chk("R7 flags before second power-on", int'(rd_data), 8'h0A);
        por_req = 1'b1;
        #1;
        chk("R8 power-on wipes other flags", int'(rd_data), 8'h01);
        repeat (2) @(negedge clk);
        por_req = 1'b0;
        #1;
        count_high(n);
        chk("R11 stretch after second power-on", n, S);
        chk("R8 flags after second power-on", int'(rd_data), 8'h01);
        chk("R1 upper bits zero", int'(rd_data[7:4]), 0);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_por_start();
        t_ext();
        t_bod();
        t_wdt();
        t_clear();
        t_same_cycle();
        t_por_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule